// File: doc/BRIEF.md
# Region-Based Secure Address Filter

This block sits between one upstream requester and one downstream memory port and decides, access by access, whether a request may pass. Each request carries an address, a read/write flag, a security flag and the requesting master's ID. The master ID is turned into a small access ID through a table of master/ID pairs fixed at build time. The address is matched against eight programmable regions; a base region covers every address that no enabled region claims. The winning region's permissions then decide whether the access goes ahead.

Permitted requests go straight through, and the downstream response comes back unchanged. A refused request never reaches the downstream port. It is answered in the same cycle with zero read data, so writes are dropped, and the response is either OKAY or an error, as software chooses. The first refusal after a clear is recorded with its address, direction, security state, master ID and access ID. A programmable interrupt can flag refusals. A gate register, closed at reset, holds off all traffic until software opens it. All control is through an APB slave.

Top module: `secure_region_filter`

## Requirements
- R1: After reset the gate is closed, the action register reads 0, regions 1..8 read 0 and `irq` is low. While the gate is closed, every access is answered at once with `rspErr`=1 and zero data, is not forwarded, and is not recorded as a failure.
- R2: Writing 1 to bit 0 at offset 0x004 opens the gate. A permitted access is then forwarded in the same cycle with its address, direction and write data unchanged. `rspValid`, `rspErr` and `rspRdata` follow the downstream response.
- R3: Region n (1..8) matches when its enable bit (attribute bit 0) is set and base <= address <= top, both bounds inclusive. A disabled region never matches.
- R4: When several regions match, the highest-numbered one decides. Region 0 decides only when none matches, and its attribute bit 0 always reads 1.
- R5: A secure access (`inNonsecure`=0) is permitted by the deciding region's attribute bit 1 for reads and bit 2 for writes.
- R6: A non-secure access with access ID k is permitted by bit k of the region's 16-bit ID mask for reads, or bit 8+k for writes.
- R7: The default map gives masters 1, 2, 5 and 9 the access IDs 1, 3, 4 and 7. Every other master gets access ID 0.
- R8: A refused access (gate open) is answered in the same cycle with `rspValid`=1 and zero read data, and `dnValid` stays low. `rspErr` equals bit 1 of the action register at offset 0x000.
- R9: When action bit 0 is set, a refused access raises `irq` from the next cycle. `irq` stays high until a write with bit 0 set reaches offset 0x008.
- R10: The first refusal after a clear is captured. Offset 0x010 holds bit 0 valid, bit 2 write and bit 3 non-secure; 0x014 holds the address; 0x018 holds the master ID in bits 3:0 and the access ID in bits 10:8. A later refusal sets only bit 1 (overrun). The clear at 0x008 zeroes the status.
- R11: Region n's registers sit at 0x100 + 0x20*n: base at +0, top at +4, attributes at +8 and the ID mask at +0xC. Each reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| inValid | input | 1 | Upstream request valid |
| inAddr | input | 32 | Upstream address |
| inWrite | input | 1 | Upstream write flag |
| inNonsecure | input | 1 | Upstream non-secure flag |
| inMasterId | input | 4 | Upstream master ID |
| inWdata | input | 32 | Upstream write data |
| rspValid | output | 1 | Response to upstream valid |
| rspErr | output | 1 | Response to upstream is an error |
| rspRdata | output | 32 | Read data to upstream |
| dnValid | output | 1 | Forwarded request valid |
| dnAddr | output | 32 | Forwarded address |
| dnWrite | output | 1 | Forwarded write flag |
| dnWdata | output | 32 | Forwarded write data |
| dnRspValid | input | 1 | Downstream response valid |
| dnRspErr | input | 1 | Downstream error |
| dnRdata | input | 32 | Downstream read data |
| irq | output | 1 | Sticky refusal interrupt |

## Verification
The bench sets up overlapping regions, a disabled region and a base region with narrow rights. It then probes the inclusive edges of each range, so a strict comparison or a lowest-region-wins priority would let a refused access through or block a permitted one. Unmapped masters are sent in to catch a map that yields a stale ID. Read and write masks are crossed to catch swapped halves. A burst of refusals checks that only the first is recorded and that the overrun flag is set, where a design that overwrote the record would report the last address. Traffic with the gate closed must leave no record and raise no interrupt, and the interrupt must hold across idle cycles until it is cleared.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int REG_IDX_W = 4;
  localparam int CFG_DATA_W = 32;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_TOP  = 2'd1,
    FLD_ATTR = 2'd2,
    FLD_MASK = 2'd3
  } field_e;

  // strobes from the register block to the region datapath
  typedef struct packed {
    logic                  we;
    logic [REG_IDX_W-1:0]  idx;
    field_e                field;
    logic [CFG_DATA_W-1:0] wdata;
  } cfgStrobe_t;
endpackage

// File: rtl/srf_datapath.sv
module srf_datapath
  import srf_pkg::*;
#(
  parameter int NUM_REG = 8,
  parameter int ADDR_W = 32,
  parameter int MID_W = 4,
  parameter int ID_W = 3,
  parameter int NUM_MAP = 4,
  parameter logic [NUM_MAP*MID_W-1:0] MAP_MID = {4'd9, 4'd5, 4'd2, 4'd1},
  parameter logic [NUM_MAP*ID_W-1:0] MAP_ID = {3'd7, 3'd4, 3'd3, 3'd1},
  parameter bit RST_R0_SECRD = 1'b0,
  parameter bit RST_R0_SECWR = 1'b0,
  parameter logic [2*(1<<ID_W)-1:0] RST_R0_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        cfg,
  output logic [CFG_DATA_W-1:0] rdVal,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  input  logic              inNonsecure,
  input  logic [MID_W-1:0]  inMasterId,
  output logic              allowed,
  output logic [ID_W-1:0]   nsaid
);
  localparam int NUM_ID = 1 << ID_W;
  localparam int MASK_W = 2 * NUM_ID;

  logic [ADDR_W-1:0] baseQ [0:NUM_REG];
  logic [ADDR_W-1:0] topQ  [0:NUM_REG];
  logic [MASK_W-1:0] maskQ [0:NUM_REG];
  logic [NUM_REG:0]  enQ, secRdQ, secWrQ;
  logic [NUM_REG:1]  hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r <= NUM_REG; r++) begin
        baseQ[r]  <= '0;
        topQ[r]   <= '0;
        maskQ[r]  <= '0;
        enQ[r]    <= 1'b0;
        secRdQ[r] <= 1'b0;
        secWrQ[r] <= 1'b0;
      end
      enQ[0]    <= 1'b1;
      secRdQ[0] <= RST_R0_SECRD;
      secWrQ[0] <= RST_R0_SECWR;
      maskQ[0]  <= RST_R0_MASK;
    end else if (cfg.we) begin
      for (int r = 0; r <= NUM_REG; r++) begin
        if (cfg.idx == REG_IDX_W'(r)) begin
          case (cfg.field)
            FLD_BASE: if (r != 0) baseQ[r] <= cfg.wdata[ADDR_W-1:0];
            FLD_TOP:  if (r != 0) topQ[r]  <= cfg.wdata[ADDR_W-1:0];
            FLD_ATTR: begin
              if (r != 0) enQ[r] <= cfg.wdata[0];
              secRdQ[r] <= cfg.wdata[1];
              secWrQ[r] <= cfg.wdata[2];
            end
            default:  maskQ[r] <= cfg.wdata[MASK_W-1:0];
          endcase
        end
      end
    end
  end

  // register readback for the slot addressed on the APB side
  always_comb begin
    rdVal = '0;
    for (int r = 0; r <= NUM_REG; r++) begin
      if (cfg.idx == REG_IDX_W'(r)) begin
        case (cfg.field)
          FLD_BASE: rdVal = CFG_DATA_W'(baseQ[r]);
          FLD_TOP:  rdVal = CFG_DATA_W'(topQ[r]);
          FLD_ATTR: rdVal = CFG_DATA_W'({secWrQ[r], secRdQ[r], enQ[r]});
          default:  rdVal = CFG_DATA_W'(maskQ[r]);
        endcase
      end
    end
  end

  for (genvar r = 1; r <= NUM_REG; r++) begin : g_match
    assign hit[r] = enQ[r] && (inAddr >= baseQ[r]) && (inAddr <= topQ[r]);
  end

  // master ID to access ID, first matching pair wins, unmapped gives 0
  always_comb begin
    logic found;
    found = 1'b0;
    nsaid = '0;
    for (int m = 0; m < NUM_MAP; m++) begin
      if (!found && inMasterId == MAP_MID[m*MID_W +: MID_W]) begin
        nsaid = MAP_ID[m*ID_W +: ID_W];
        found = 1'b1;
      end
    end
  end

  logic              selRd, selWr;
  logic [MASK_W-1:0] selMask;

  // base region first, higher-numbered hits override
  always_comb begin
    selRd   = secRdQ[0];
    selWr   = secWrQ[0];
    selMask = maskQ[0];
    for (int r = 1; r <= NUM_REG; r++) begin
      if (hit[r]) begin
        selRd   = secRdQ[r];
        selWr   = secWrQ[r];
        selMask = maskQ[r];
      end
    end
  end

  assign allowed = inNonsecure ? selMask[{inWrite, nsaid}]
                               : (inWrite ? selWr : selRd);
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
#(
  parameter int NUM_REG = 8,
  parameter int ADDR_W = 32,
  parameter int MID_W = 4,
  parameter int ID_W = 3,
  parameter logic [1:0] RST_ACTION = 2'b00,
  parameter bit RST_GATE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output cfgStrobe_t        cfg,
  input  logic [CFG_DATA_W-1:0] regionRd,
  input  logic              evtValid,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic              evtWrite,
  input  logic              evtNs,
  input  logic [MID_W-1:0]  evtMid,
  input  logic [ID_W-1:0]   evtId,
  output logic              gateOpen,
  output logic [1:0]        action,
  output logic              irq
);
  localparam logic [11:0] ADR_ACTION = 12'h000;
  localparam logic [11:0] ADR_GATE   = 12'h004;
  localparam logic [11:0] ADR_CLEAR  = 12'h008;
  localparam logic [11:0] ADR_FSTAT  = 12'h010;
  localparam logic [11:0] ADR_FADDR  = 12'h014;
  localparam logic [11:0] ADR_FID    = 12'h018;
  localparam logic [11:0] ADR_REGION = 12'h100;
  localparam int SLOT_LSB = 5;

  logic        wrEn, clrHit, inRegion;
  logic [11:0] regOff;
  logic [REG_IDX_W-1:0] regIdx;

  assign wrEn   = psel && penable && pwrite;
  assign regOff = paddr - ADR_REGION;
  assign regIdx = regOff[SLOT_LSB +: REG_IDX_W];
  assign inRegion = (paddr >= ADR_REGION) && ((regOff >> (SLOT_LSB + REG_IDX_W)) == '0)
                 && !regOff[4] && (regOff[1:0] == 2'b00)
                 && (regIdx <= REG_IDX_W'(NUM_REG));
  assign clrHit = wrEn && (paddr == ADR_CLEAR) && pwdata[0];

  assign cfg.we    = wrEn && inRegion;
  assign cfg.idx   = regIdx;
  assign cfg.field = field_e'(regOff[3:2]);
  assign cfg.wdata = pwdata;

  logic              failValidQ, overrunQ, failWriteQ, failNsQ;
  logic [ADDR_W-1:0] failAddrQ;
  logic [MID_W-1:0]  failMidQ;
  logic [ID_W-1:0]   failIdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      action   <= RST_ACTION;
      gateOpen <= RST_GATE;
    end else if (wrEn) begin
      if (paddr == ADR_ACTION) action   <= pwdata[1:0];
      if (paddr == ADR_GATE)   gateOpen <= pwdata[0];
    end
  end

  // first refusal after a clear is kept, later ones only mark overrun
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failValidQ <= 1'b0;
      overrunQ   <= 1'b0;
      failWriteQ <= 1'b0;
      failNsQ    <= 1'b0;
      failAddrQ  <= '0;
      failMidQ   <= '0;
      failIdQ    <= '0;
      irq        <= 1'b0;
    end else begin
      if (clrHit) begin
        failValidQ <= 1'b0;
        overrunQ   <= 1'b0;
        failWriteQ <= 1'b0;
        failNsQ    <= 1'b0;
        irq        <= 1'b0;
      end
      if (evtValid) begin
        if (!failValidQ || clrHit) begin
          failValidQ <= 1'b1;
          failWriteQ <= evtWrite;
          failNsQ    <= evtNs;
          failAddrQ  <= evtAddr;
          failMidQ   <= evtMid;
          failIdQ    <= evtId;
        end else begin
          overrunQ <= 1'b1;
        end
        if (action[0]) irq <= 1'b1;
      end
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      ADR_ACTION: prdata = 32'(action);
      ADR_GATE:   prdata = 32'(gateOpen);
      ADR_FSTAT:  prdata = 32'({failNsQ, failWriteQ, overrunQ, failValidQ});
      ADR_FADDR:  prdata = 32'(failAddrQ);
      ADR_FID: begin
        prdata[MID_W-1:0]  = failMidQ;
        prdata[8 +: ID_W]  = failIdQ;
      end
      default:    if (inRegion) prdata = regionRd;
    endcase
  end
endmodule

// File: rtl/secure_region_filter.sv
module secure_region_filter
  import srf_pkg::*;
#(
  parameter int NUM_REG = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W = 4,
  parameter int ID_W = 3,
  parameter int NUM_MAP = 4,
  parameter logic [NUM_MAP*MID_W-1:0] MAP_MID = {4'd9, 4'd5, 4'd2, 4'd1},
  parameter logic [NUM_MAP*ID_W-1:0] MAP_ID = {3'd7, 3'd4, 3'd3, 3'd1},
  parameter logic [1:0] RST_ACTION = 2'b00,
  parameter bit RST_GATE = 1'b0,
  parameter bit RST_R0_SECRD = 1'b0,
  parameter bit RST_R0_SECWR = 1'b0,
  parameter logic [2*(1<<ID_W)-1:0] RST_R0_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  input  logic              inNonsecure,
  input  logic [MID_W-1:0]  inMasterId,
  input  logic [DATA_W-1:0] inWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              dnValid,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  input  logic              dnRspValid,
  input  logic              dnRspErr,
  input  logic [DATA_W-1:0] dnRdata,
  output logic              irq
);
  cfgStrobe_t            cfg;
  logic [CFG_DATA_W-1:0] regionRd;
  logic                  allowed, gateOpen, fwd, denied;
  logic [ID_W-1:0]       nsaid;
  logic [1:0]            action;

  srf_datapath #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .MID_W(MID_W), .ID_W(ID_W),
    .NUM_MAP(NUM_MAP), .MAP_MID(MAP_MID), .MAP_ID(MAP_ID),
    .RST_R0_SECRD(RST_R0_SECRD), .RST_R0_SECWR(RST_R0_SECWR),
    .RST_R0_MASK(RST_R0_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .rdVal(regionRd),
    .inAddr(inAddr), .inWrite(inWrite), .inNonsecure(inNonsecure),
    .inMasterId(inMasterId), .allowed(allowed), .nsaid(nsaid)
  );

  srf_ctrl #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .MID_W(MID_W), .ID_W(ID_W),
    .RST_ACTION(RST_ACTION), .RST_GATE(RST_GATE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cfg(cfg),
    .regionRd(regionRd), .evtValid(denied), .evtAddr(inAddr),
    .evtWrite(inWrite), .evtNs(inNonsecure), .evtMid(inMasterId),
    .evtId(nsaid), .gateOpen(gateOpen), .action(action), .irq(irq)
  );

  assign pready = 1'b1;
  assign fwd    = inValid && gateOpen && allowed;
  assign denied = inValid && gateOpen && !allowed;

  assign dnValid = fwd;
  assign dnAddr  = inAddr;
  assign dnWrite = inWrite;
  assign dnWdata = inWdata;

  assign rspValid = fwd ? dnRspValid : inValid;
  assign rspErr   = fwd ? dnRspErr : ((inValid && !gateOpen) || (denied && action[1]));
  assign rspRdata = fwd ? dnRdata : '0;
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [11:0]       paddr,
  input logic              clrBit,
  input logic              inValid,
  input logic              dnValid,
  input logic              rspValid,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspRdata,
  input logic              irq,
  input logic              gateOpen,
  input logic [1:0]        action
);
  logic clrWr;
  assign clrWr = psel && penable && pwrite && (paddr == 12'h008) && clrBit;

  // R1
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !gateOpen |-> !dnValid);

  // R2
  fwd_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnValid |-> inValid);

  // R8
  deny_raz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !dnValid) |-> (rspValid && rspRdata == '0));

  // R8
  deny_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !dnValid && gateOpen) |-> (rspErr == action[1]));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(inValid && !dnValid && gateOpen && action[0]));
endmodule

bind secure_region_filter srf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .clrBit(pwdata[0]), .inValid(inValid), .dnValid(dnValid),
  .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata), .irq(irq),
  .gateOpen(gateOpen), .action(action)
);

// File: tb/secure_region_filter_tb.sv
`timescale 1ns/1ps
module secure_region_filter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready;
  logic inValid = 0, inWrite = 0, inNonsecure = 0;
  logic [31:0] inAddr = '0, inWdata = '0;
  logic [3:0] inMasterId = '0;
  logic rspValid, rspErr, dnValid, dnWrite, irq;
  logic [31:0] rspRdata, dnAddr, dnWdata;
  logic dnRspValid = 1'b1, dnRspErr = 1'b0;
  logic [31:0] dnRdata = '0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  secure_region_filter u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .inValid(inValid), .inAddr(inAddr), .inWrite(inWrite),
    .inNonsecure(inNonsecure), .inMasterId(inMasterId), .inWdata(inWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .dnValid(dnValid), .dnAddr(dnAddr), .dnWrite(dnWrite), .dnWdata(dnWdata),
    .dnRspValid(dnRspValid), .dnRspErr(dnRspErr), .dnRdata(dnRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  // one-cycle access; outputs sampled mid-cycle, request dropped after one edge
  task automatic access(input logic [31:0] a, input logic wr, input logic ns,
                        input logic [3:0] mid, output logic fw, output logic err,
                        output logic rv, output logic [31:0] rd);
    @(negedge clk);
    inValid = 1; inAddr = a; inWrite = wr; inNonsecure = ns; inMasterId = mid;
    inWdata = a ^ 32'h5A5A_0000;
    #1;
    fw = dnValid; err = rspErr; rv = rspValid; rd = rspRdata;
    @(negedge clk);
    inValid = 0;
  endtask

  // {addr, write, nonsecure, masterId, expectAllow}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {32'h0000_1004, 1'b0, 1'b1, 4'd1, 1'b1},  // R6 R7 read id1 in region 1
    {32'h0000_1004, 1'b1, 1'b1, 4'd2, 1'b0},  // R6 write id3 not granted
    {32'h0000_1004, 1'b1, 1'b1, 4'd1, 1'b1},  // R6 write id1 granted
    {32'h0000_1804, 1'b0, 1'b1, 4'd1, 1'b0},  // R4 region 2 overrides 1
    {32'h0000_1804, 1'b0, 1'b1, 4'd5, 1'b1},  // R4 R7 id4 in region 2
    {32'h0000_1804, 1'b0, 1'b0, 4'd1, 1'b0},  // R5 secure read refused in region 2
    {32'h0000_1004, 1'b1, 1'b0, 4'd1, 1'b1},  // R5 secure write in region 1
    {32'h0000_8004, 1'b0, 1'b1, 4'd7, 1'b1},  // R3 R7 disabled region, base id0
    {32'h0000_8004, 1'b1, 1'b1, 4'd7, 1'b0},  // R4 base region write mask empty
    {32'h0000_0000, 1'b0, 1'b0, 4'd0, 1'b1},  // R5 base secure read
    {32'h0000_0000, 1'b1, 1'b0, 4'd0, 1'b0},  // R5 base secure write
    {32'h0000_1FFF, 1'b0, 1'b1, 4'd2, 1'b1},  // R3 top inclusive
    {32'h0000_2000, 1'b0, 1'b1, 4'd2, 1'b0},  // R3 one past top
    {32'h0000_17FF, 1'b0, 1'b1, 4'd5, 1'b0},  // R4 just below region 2
    {32'h0000_1800, 1'b0, 1'b1, 4'd5, 1'b1}   // R3 base inclusive
  };

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic fw, err, rv;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    apbRead(12'h000, rd); chk("R1 action reset", rd, 32'h0);
    apbRead(12'h124, rd); chk("R1 region1 top reset", rd, 32'h0);
    access(32'h0000_1004, 1'b0, 1'b1, 4'd1, fw, err, rv, rd);
    chk("R1 closed gate forward", 32'(fw), 32'h0);
    chk("R1 closed gate error", 32'(err), 32'h1);
    chk("R1 closed gate data", rd, 32'h0);
    apbRead(12'h010, rd); chk("R1 closed gate no record", rd, 32'h0);

    // configuration
    apbWrite(12'h108, 32'h2);        // region 0: secure read
    apbWrite(12'h10C, 32'h0001);     // region 0: read id0
    apbWrite(12'h120, 32'h0000_1000);
    apbWrite(12'h124, 32'h0000_1FFF);
    apbWrite(12'h128, 32'h7);
    apbWrite(12'h12C, 32'h020A);     // read ids 1,3; write id1
    apbWrite(12'h140, 32'h0000_1800);
    apbWrite(12'h144, 32'h0000_18FF);
    apbWrite(12'h148, 32'h1);
    apbWrite(12'h14C, 32'h1010);     // read and write id4
    apbWrite(12'h1A0, 32'h0000_8000);
    apbWrite(12'h1A4, 32'h0000_8FFF);
    apbWrite(12'h1A8, 32'h6);        // disabled
    apbWrite(12'h1AC, 32'hFFFF);
    apbWrite(12'h004, 32'h1);

    // R11 readback
    apbRead(12'h124, rd); chk("R11 region1 top", rd, 32'h0000_1FFF);
    apbRead(12'h14C, rd); chk("R11 region2 mask", rd, 32'h1010);
    apbRead(12'h108, rd); chk("R4 R11 region0 attr", rd, 32'h3);

    // vector walk, action 00
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      dnRdata = 32'hCAFE_0000 + 32'(i);
      @(negedge clk);
      inValid = 1; inAddr = v[38:7]; inWrite = v[6]; inNonsecure = v[5];
      inMasterId = v[4:1]; inWdata = 32'h1234_0000 + 32'(i);
      #1;
      chk($sformatf("R3-6 vec%0d forward", i), 32'(dnValid), 32'(v[0]));
      chk($sformatf("R8 vec%0d rspValid", i), 32'(rspValid), 32'h1);
      chk($sformatf("R8 vec%0d rspErr", i), 32'(rspErr), 32'h0);
      if (v[0]) begin
        chk($sformatf("R2 vec%0d data", i), rspRdata, 32'hCAFE_0000 + 32'(i));
        chk($sformatf("R2 vec%0d addr", i), dnAddr, v[38:7]);
        chk($sformatf("R2 vec%0d wdata", i), dnWdata, 32'h1234_0000 + 32'(i));
      end else begin
        chk($sformatf("R8 vec%0d zero data", i), rspRdata, 32'h0);
      end
    end
    @(negedge clk);
    inValid = 0;

    // R10 first refusal held, overrun set, R9 no irq with action 00
    chk("R9 no irq action 00", 32'(irq), 32'h0);
    apbRead(12'h010, rd); chk("R10 status", rd, 32'hF);
    apbRead(12'h014, rd); chk("R10 address", rd, 32'h0000_1004);
    apbRead(12'h018, rd); chk("R10 id", rd, 32'h0000_0302);
    apbWrite(12'h008, 32'h1);
    apbRead(12'h010, rd); chk("R10 clear", rd, 32'h0);

    // action 11: error and interrupt
    apbWrite(12'h000, 32'h3);
    access(32'h0000_2000, 1'b0, 1'b1, 4'd2, fw, err, rv, rd);
    chk("R8 error response", 32'(err), 32'h1);
    chk("R9 irq raised", 32'(irq), 32'h1);
    repeat (4) @(negedge clk);
    chk("R9 irq held", 32'(irq), 32'h1);
    apbRead(12'h010, rd); chk("R10 read ns status", rd, 32'h9);
    apbRead(12'h014, rd); chk("R10 second address", rd, 32'h0000_2000);
    apbWrite(12'h008, 32'h1);
    chk("R9 irq cleared", 32'(irq), 32'h0);

    // action 01: OKAY with interrupt, unmapped secure master
    apbWrite(12'h000, 32'h1);
    access(32'h0000_0000, 1'b1, 1'b0, 4'd12, fw, err, rv, rd);
    chk("R8 okay response", 32'(err), 32'h0);
    chk("R8 not forwarded", 32'(fw), 32'h0);
    chk("R9 irq action 01", 32'(irq), 32'h1);
    apbRead(12'h010, rd); chk("R10 secure write status", rd, 32'h5);
    apbRead(12'h018, rd); chk("R7 R10 unmapped id", rd, 32'h0000_000C);
    apbWrite(12'h008, 32'h1);

    // R1 gate closed again: blocked, not recorded, no irq
    apbWrite(12'h004, 32'h0);
    access(32'h0000_1004, 1'b0, 1'b1, 4'd1, fw, err, rv, rd);
    chk("R1 reclosed forward", 32'(fw), 32'h0);
    chk("R1 reclosed error", 32'(err), 32'h1);
    chk("R1 reclosed valid", 32'(rv), 32'h1);
    chk("R1 reclosed irq", 32'(irq), 32'h0);
    apbRead(12'h010, rd); chk("R1 reclosed no record", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule